// File: doc/BRIEF.md
# Character-Cell Text Overlay Renderer

This block paints a text layer onto a raster display that scans 640x480 pixels. The screen is divided into cells eight pixels wide and sixteen lines tall, so a frame holds 80 columns by 30 rows of characters. For every pixel coordinate the block reports which cell is being scanned. Upstream logic uses that cell index to choose a 7-bit character code and a 3-bit foreground colour, and feeds both back in on the same cycle as the coordinates.

Inside the block, the character code and the line within the cell form an address into a synchronous glyph store. The store returns one 8-pixel slice of the glyph, and the column within the cell picks one pixel from it. That pixel is then gated with the colour to give 1-bit-per-channel RGB. Black is the background colour. A message can be hidden by driving its colour to zero.

The coordinates and the colour travel through delay registers alongside the address and data stages. This keeps the pixel and its colour aligned, so characters are neither shifted sideways nor shown in the colour of their neighbour. The built-in glyph store holds the digits 0 to 8 and a mine symbol. Every other code renders blank.

Top module: `text_overlay_render`

## Requirements
- R1: `cell_col` equals `px_x` divided by 8 and `cell_row` equals `px_y` divided by 16, combinationally. Pixel (639,479) lies in cell column 79, row 29.
- R2: `rgb` shows the pixel whose coordinates, code and colour were presented three rising clock edges earlier. The colour on `rgb` always belongs to that same pixel.
- R3: The glyph line is addressed by the character code in the upper address bits and `px_y[3:0]` in the lower four. Within a glyph line, bit 7 is the leftmost pixel, so column c (`px_x[2:0]` = c) shows bit 7-c and glyphs are not mirrored.
- R4: Each of the three `rgb` channels is the glyph pixel ANDed with the matching bit of `fg_rgb`. A colour of zero gives black whatever the glyph.
- R5: Codes 0x30 to 0x38 draw the digits 0 to 8 as seven-segment figures:
  - the top bar is on line 2, the middle bar on line 7 and the bottom bar on line 12, each bar covering columns 1 to 6;
  - the upper left and upper right strokes are columns 1 and 6 on lines 3 to 6;
  - the lower left and lower right strokes are columns 1 and 6 on lines 8 to 11.
- R6: Code 0x2A draws a mine:
  - line 3 has only column 5 lit;
  - lines 4 and 11 have columns 3 to 4 lit;
  - lines 5 and 10 have columns 2 to 5 lit;
  - lines 6 to 9 have columns 1 to 6 lit.
- R7: Every code other than 0x2A and 0x30 to 0x38 renders black in all 128 pixels of its cell.
- R8: Lines 0, 1, 13, 14 and 15 of every glyph are black.
- R9: The active-low reset acts at once when asserted and forces `rgb` to black. Its release is synchronised over two clock edges, and `rgb` stays black until new pixels have passed through the pipeline.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| px_x | input | 10 | Horizontal pixel coordinate |
| px_y | input | 10 | Vertical pixel coordinate |
| chr_code | input | 7 | Character code for the cell being scanned |
| fg_rgb | input | 3 | Foreground colour for that character, {R,G,B} |
| cell_col | output | 7 | Cell column index of the current pixel |
| cell_row | output | 6 | Cell row index of the current pixel |
| rgb | output | 3 | Rendered pixel colour, {R,G,B} |

## Verification
The assertions check four properties on every cycle, each judged against the inputs of three edges before:
- `rgb` never lights a channel that the colour of that pixel leaves off;
- a lit output always carries that pixel's exact colour;
- blank margin lines stay dark;
- codes outside the defined set stay dark.

Only the bench's scenarios can show the rest. These are the exact glyph shapes, the left-to-right bit order that prevents mirroring, the cell index arithmetic at the screen corner, and the reset behaviour both at power-up and in the middle of a stream.

// File: rtl/txt_ovl_pkg.sv
package txt_ovl_pkg;
  localparam int unsigned X_W     = 10;
  localparam int unsigned Y_W     = 10;
  localparam int unsigned CODE_W  = 7;
  localparam int unsigned RGB_W   = 3;
  localparam int unsigned GLYPH_W = 8;
  localparam int unsigned GLYPH_H = 16;

  localparam int unsigned COL_BITS = $clog2(GLYPH_W);
  localparam int unsigned ROW_BITS = $clog2(GLYPH_H);
  localparam int unsigned ADDR_W   = CODE_W + ROW_BITS;

  localparam logic [CODE_W-1:0] CODE_DIGIT0 = 7'h30;
  localparam int unsigned       N_DIGITS    = 9;
  localparam logic [CODE_W-1:0] CODE_MINE   = 7'h2A;

  typedef logic [GLYPH_W-1:0] glyph_line_t;

  // Side information that must ride along with the glyph address.
  typedef struct packed {
    logic [COL_BITS-1:0] col;
    logic [RGB_W-1:0]    colour;
  } side_t;

  localparam int unsigned SIDE_W = COL_BITS + RGB_W;
endpackage

// File: rtl/txt_ovl_addr_stage.sv
module txt_ovl_addr_stage
  import txt_ovl_pkg::*;
#(
  parameter int unsigned CODE_BITS = CODE_W,
  parameter int unsigned LINE_BITS = ROW_BITS,
  localparam int unsigned AW       = CODE_BITS + LINE_BITS
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [CODE_BITS-1:0] code_i,
  input  logic [LINE_BITS-1:0] line_i,
  input  side_t                side_i,
  output logic [AW-1:0]        addr_o,
  output side_t                side_o
);
  logic [AW-1:0] addr_d;
  logic [AW-1:0] addr_q;
  side_t         side_d;
  side_t         side_q;
  logic          en;

  always_comb begin
    en     = 1'b1;
    addr_d = {code_i, line_i};
    side_d = side_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      side_q <= '0;
    end else if (en) begin
      addr_q <= addr_d;
      side_q <= side_d;
    end
  end

  assign addr_o = addr_q;
  assign side_o = side_q;
endmodule

// File: rtl/txt_ovl_glyph_rom.sv
module txt_ovl_glyph_rom
  import txt_ovl_pkg::*;
#(
  parameter int unsigned CODE_BITS = CODE_W,
  parameter int unsigned LINE_BITS = ROW_BITS,
  localparam int unsigned AW       = CODE_BITS + LINE_BITS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr_i,
  output glyph_line_t   data_o
);
  localparam glyph_line_t BAR   = 8'h7E;
  localparam glyph_line_t LEFT  = 8'h40;
  localparam glyph_line_t RIGHT = 8'h02;

  // Segment set per digit, ordered {top, upper-right, lower-right, bottom,
  // lower-left, upper-left, middle}.
  function automatic logic [6:0] seg_set(input logic [3:0] digit);
    case (digit)
      4'd0:    seg_set = 7'b1111110;
      4'd1:    seg_set = 7'b0110000;
      4'd2:    seg_set = 7'b1101101;
      4'd3:    seg_set = 7'b1111001;
      4'd4:    seg_set = 7'b0110011;
      4'd5:    seg_set = 7'b1011011;
      4'd6:    seg_set = 7'b1011111;
      4'd7:    seg_set = 7'b1110000;
      4'd8:    seg_set = 7'b1111111;
      default: seg_set = 7'b0000000;
    endcase
  endfunction

  function automatic glyph_line_t digit_line(input logic [6:0] s, input logic [LINE_BITS-1:0] ln);
    glyph_line_t v;
    v = '0;
    if (ln == 2)               v = s[6] ? BAR : '0;
    else if (ln >= 3 && ln <= 6)
      v = (s[1] ? LEFT : '0) | (s[5] ? RIGHT : '0);
    else if (ln == 7)          v = s[0] ? BAR : '0;
    else if (ln >= 8 && ln <= 11)
      v = (s[2] ? LEFT : '0) | (s[4] ? RIGHT : '0);
    else if (ln == 12)         v = s[3] ? BAR : '0;
    return v;
  endfunction

  function automatic glyph_line_t mine_line(input logic [LINE_BITS-1:0] ln);
    case (ln)
      4'd3:               mine_line = 8'h04;
      4'd4, 4'd11:        mine_line = 8'h18;
      4'd5, 4'd10:        mine_line = 8'h3C;
      4'd6, 4'd7,
      4'd8, 4'd9:         mine_line = 8'h7E;
      default:            mine_line = 8'h00;
    endcase
  endfunction

  logic [CODE_BITS-1:0] code;
  logic [LINE_BITS-1:0] line;
  logic [CODE_BITS-1:0] digit_off;
  glyph_line_t          data_d;
  glyph_line_t          data_q;
  logic                 en;

  always_comb begin
    en        = 1'b1;
    code      = addr_i[AW-1:LINE_BITS];
    line      = addr_i[LINE_BITS-1:0];
    digit_off = code - CODE_DIGIT0;
    if (code == CODE_MINE)
      data_d = mine_line(line);
    else if (code >= CODE_DIGIT0 && digit_off < CODE_BITS'(N_DIGITS))
      data_d = digit_line(seg_set(digit_off[3:0]), line);
    else
      data_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   data_q <= '0;
    else if (en)  data_q <= data_d;
  end

  assign data_o = data_q;
endmodule

// File: rtl/txt_ovl_dly.sv
module txt_ovl_dly #(
  parameter int unsigned W     = 6,
  parameter int unsigned DEPTH = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  generate
    if (DEPTH == 0) begin : g_pass
      assign q_o = d_i;
    end else begin : g_chain
      logic [W-1:0] stage_q [DEPTH];
      logic [W-1:0] stage_d [DEPTH];
      logic         en;

      always_comb begin
        en = 1'b1;
        stage_d[0] = d_i;
        for (int i = 1; i < DEPTH; i++) stage_d[i] = stage_q[i-1];
      end

      for (genvar g = 0; g < DEPTH; g++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n)  stage_q[g] <= '0;
          else if (en) stage_q[g] <= stage_d[g];
        end
      end

      assign q_o = stage_q[DEPTH-1];
    end
  endgenerate
endmodule

// File: rtl/txt_ovl_pix_sel.sv
module txt_ovl_pix_sel
  import txt_ovl_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  glyph_line_t line_i,
  input  side_t       side_i,
  output logic [RGB_W-1:0] rgb_o
);
  logic             pix_d;
  logic             pix_q;
  logic [RGB_W-1:0] colour_d;
  logic [RGB_W-1:0] colour_q;
  logic [COL_BITS-1:0] bit_idx;
  logic             en;

  always_comb begin
    en       = 1'b1;
    // Leftmost pixel is the most significant glyph bit.
    bit_idx  = ~side_i.col;
    pix_d    = line_i[bit_idx];
    colour_d = side_i.colour;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pix_q    <= 1'b0;
      colour_q <= '0;
    end else if (en) begin
      pix_q    <= pix_d;
      colour_q <= colour_d;
    end
  end

  assign rgb_o = {RGB_W{pix_q}} & colour_q;
endmodule

// File: rtl/text_overlay_render.sv
module text_overlay_render
  import txt_ovl_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [X_W-1:0]         px_x,
  input  logic [Y_W-1:0]         px_y,
  input  logic [CODE_W-1:0]      chr_code,
  input  logic [RGB_W-1:0]       fg_rgb,
  output logic [X_W-COL_BITS-1:0] cell_col,
  output logic [Y_W-ROW_BITS-1:0] cell_row,
  output logic [RGB_W-1:0]       rgb
);
  localparam int unsigned SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[SYNC_STAGES-1];

  assign cell_col = px_x[X_W-1:COL_BITS];
  assign cell_row = px_y[Y_W-1:ROW_BITS];

  side_t            side_in;
  side_t            side_s1;
  side_t            side_s2;
  logic [ADDR_W-1:0] rom_addr;
  glyph_line_t      rom_line;

  always_comb begin
    side_in.col    = px_x[COL_BITS-1:0];
    side_in.colour = fg_rgb;
  end

  txt_ovl_addr_stage #(
    .CODE_BITS(CODE_W),
    .LINE_BITS(ROW_BITS)
  ) u_addr (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .code_i (chr_code),
    .line_i (px_y[ROW_BITS-1:0]),
    .side_i (side_in),
    .addr_o (rom_addr),
    .side_o (side_s1)
  );

  txt_ovl_glyph_rom #(
    .CODE_BITS(CODE_W),
    .LINE_BITS(ROW_BITS)
  ) u_rom (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .addr_i (rom_addr),
    .data_o (rom_line)
  );

  // Matches the one-cycle read latency of the glyph store.
  txt_ovl_dly #(
    .W    (SIDE_W),
    .DEPTH(1)
  ) u_side_dly (
    .clk   (clk),
    .rst_n (rst_n_int),
    .d_i   (side_s1),
    .q_o   (side_s2)
  );

  txt_ovl_pix_sel u_sel (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .line_i (rom_line),
    .side_i (side_s2),
    .rgb_o  (rgb)
  );
endmodule

// File: rtl/txt_ovl_chk.sv
module txt_ovl_chk
  import txt_ovl_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [Y_W-1:0]    px_y,
  input logic [CODE_W-1:0] chr_code,
  input logic [RGB_W-1:0]  fg_rgb,
  input logic [RGB_W-1:0]  rgb
);
  localparam int unsigned WARM = 6;
  logic [2:0] warm_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   warm_q <= '0;
    else if (warm_q != 3'(WARM))  warm_q <= warm_q + 3'd1;
  end

  logic ready;
  assign ready = (warm_q == 3'(WARM));

  AST_NO_FOREIGN_CHANNEL: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> ((rgb & ~$past(fg_rgb, 3)) == '0)); // R4

  AST_COLOUR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && rgb != '0) |-> (rgb == $past(fg_rgb, 3))); // R2

  AST_MARGIN_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && ($past(px_y[3:0], 3) <= 4'd1 || $past(px_y[3:0], 3) >= 4'd13))
      |-> (rgb == '0)); // R8

  AST_UNDEFINED_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && $past(chr_code, 3) != CODE_MINE &&
     ($past(chr_code, 3) < 7'h30 || $past(chr_code, 3) > 7'h38))
      |-> (rgb == '0)); // R7
endmodule

bind text_overlay_render txt_ovl_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .px_y     (px_y),
  .chr_code (chr_code),
  .fg_rgb   (fg_rgb),
  .rgb      (rgb)
);

// File: tb/sim_text_overlay_render.sv
module sim_text_overlay_render;
  logic       clk;
  logic       rst_n;
  logic [9:0] px_x;
  logic [9:0] px_y;
  logic [6:0] chr_code;
  logic [2:0] fg_rgb;
  logic [6:0] cell_col;
  logic [5:0] cell_row;
  logic [2:0] rgb;

  int n_cmp;
  int n_bad;
  bit done;

  logic [9:0] hx [3];
  logic [9:0] hy [3];
  logic [6:0] hc [3];
  logic [2:0] hf [3];
  int         hv;

  text_overlay_render u0 (
    .clk(clk), .rst_n(rst_n), .px_x(px_x), .px_y(px_y),
    .chr_code(chr_code), .fg_rgb(fg_rgb),
    .cell_col(cell_col), .cell_row(cell_row), .rgb(rgb)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // Pixel lit according to the glyph shapes in the requirements.
  function automatic bit glyph_on(input logic [6:0] code, input int ln, input int col);
    bit bar, sa, sb, sc, sd, se, sf, sg;
    int d;
    bar = (col >= 1 && col <= 6);
    if (code == 7'h2A) begin // R6
      if (ln == 3) return col == 5;
      if (ln == 4 || ln == 11) return col >= 3 && col <= 4;
      if (ln == 5 || ln == 10) return col >= 2 && col <= 5;
      if (ln >= 6 && ln <= 9) return bar;
      return 0;
    end
    if (code < 7'h30 || code > 7'h38) return 0; // R7
    d  = int'(code) - 'h30;
    sa = d inside {0, 2, 3, 5, 6, 7, 8};
    sb = d inside {0, 1, 2, 3, 4, 7, 8};
    sc = d inside {0, 1, 3, 4, 5, 6, 7, 8};
    sd = d inside {0, 2, 3, 5, 6, 8};
    se = d inside {0, 2, 6, 8};
    sf = d inside {0, 4, 5, 6, 8};
    sg = d inside {2, 3, 4, 5, 6, 8};
    if (ln == 2)  return sa && bar;
    if (ln == 7)  return sg && bar;
    if (ln == 12) return sd && bar;
    if (ln >= 3 && ln <= 6)  return (sf && col == 1) || (sb && col == 6);
    if (ln >= 8 && ln <= 11) return (se && col == 1) || (sc && col == 6);
    return 0; // R8
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Drive one pixel; first compare the output with the pixel driven three edges earlier.
  task automatic step(input logic [9:0] x, input logic [9:0] y, input logic [6:0] c,
                      input logic [2:0] f, input string tag);
    @(negedge clk);
    if (hv >= 3)
      check(tag, int'(rgb),
            glyph_on(hc[2], int'(hy[2][3:0]), int'(hx[2][2:0])) ? int'(hf[2]) : 0);
    for (int i = 2; i > 0; i--) begin
      hx[i] = hx[i-1]; hy[i] = hy[i-1]; hc[i] = hc[i-1]; hf[i] = hf[i-1];
    end
    hx[0] = x; hy[0] = y; hc[0] = c; hf[0] = f;
    px_x = x; px_y = y; chr_code = c; fg_rgb = f;
    hv++;
  endtask

  task automatic flush(input string tag);
    for (int i = 0; i < 3; i++) step(10'd0, 10'd0, 7'h20, 3'd0, tag);
  endtask

  task automatic scan_cell(input logic [6:0] c, input int cx, input int cy,
                           input logic [2:0] f, input string tag);
    for (int ln = 0; ln < 16; ln++)
      for (int col = 0; col < 8; col++)
        step(10'(cx * 8 + col), 10'(cy * 16 + ln), c, f, tag);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; px_x = '0; px_y = '0; chr_code = '0; fg_rgb = '0; hv = 0;
    repeat (3) @(negedge clk);
    check("R9 rgb dark in reset", int'(rgb), 0);
    rst_n = 1'b1;
    repeat (2) begin
      @(negedge clk);
      check("R9 rgb dark after release", int'(rgb), 0);
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic t_cells();
    @(negedge clk);
    px_x = 10'd639; px_y = 10'd479; #1;
    check("R1 corner col", int'(cell_col), 79);
    check("R1 corner row", int'(cell_row), 29);
    px_x = 10'd8; px_y = 10'd16; #1;
    check("R1 col edge", int'(cell_col), 1);
    check("R1 row edge", int'(cell_row), 1);
    px_x = 10'd7; px_y = 10'd15; #1;
    check("R1 origin col", int'(cell_col), 0);
    check("R1 origin row", int'(cell_row), 0);
  endtask

  task automatic t_digits();
    for (int d = 0; d < 9; d++)
      scan_cell(7'(8'h30 + d), 10 + d, 5, 3'b111, "R5 R3 R8 digit scan");
    flush("R5 digit flush");
  endtask

  task automatic t_mine();
    scan_cell(7'h2A, 79, 29, 3'b101, "R6 R3 mine scan");
    flush("R6 mine flush");
  endtask

  task automatic t_mirror();
    // Digit 1 lights only column 6 on line 4; column 1 stays dark.
    step(10'd6, 10'd4, 7'h31, 3'b010, "R3 right column");
    step(10'd1, 10'd4, 7'h31, 3'b010, "R3 left column");
    step(10'd0, 10'd3, 7'h2A, 3'b011, "R3 mine col0");
    step(10'd5, 10'd3, 7'h2A, 3'b011, "R3 mine col5");
    step(10'd2, 10'd3, 7'h2A, 3'b011, "R3 mine col2");
    flush("R3 mirror flush");
  endtask

  task automatic t_blank();
    logic [6:0] codes [5] = '{7'h00, 7'h20, 7'h29, 7'h39, 7'h7F};
    foreach (codes[i]) scan_cell(codes[i], i, 0, 3'b111, "R7 blank code");
    flush("R7 blank flush");
  endtask

  task automatic t_colour();
    // Colour changes every pixel along the lit middle bar of digit 8.
    for (int k = 0; k < 64; k++)
      step(10'(k), 10'd7, 7'h38, 3'(k % 8), "R4 R2 colour per pixel");
    for (int k = 0; k < 32; k++)
      step(10'(k), 10'd2, 7'h38, 3'd0, "R4 hidden colour");
    flush("R4 flush");
  endtask

  task automatic t_reset_mid();
    for (int k = 0; k < 6; k++) step(10'd3, 10'd7, 7'h38, 3'b111, "R9 prefill");
    check("R9 lit before reset", int'(rgb), 7);
    @(negedge clk);
    rst_n = 1'b0; #1;
    check("R9 immediate dark", int'(rgb), 0);
    repeat (2) @(negedge clk);
    check("R9 dark held", int'(rgb), 0);
    rst_n = 1'b1;
    repeat (3) begin
      @(negedge clk);
      check("R9 dark during release", int'(rgb), 0);
    end
    @(negedge clk);
    hv = 0;
    for (int k = 0; k < 6; k++) step(10'(k), 10'd7, 7'h38, 3'b110, "R9 R2 resume");
    flush("R9 flush");
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    n_cmp = 0; n_bad = 0; done = 1'b0;
    t_reset();
    t_cells();
    t_digits();
    t_mine();
    t_mirror();
    t_blank();
    t_colour();
    t_reset_mid();
    finish_run();
  end

  initial begin
    #(5 * 200000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule